// File: doc/BRIEF.md
# Request-Driven Single-Transfer Service Engine

This engine moves one data item each time a peripheral asks for service. The item is a byte or a 16-bit word. It moves between a peripheral's I/O address and a location in a memory buffer. Software first programs an 8-bit control register, a 24-bit buffer pointer (an 8-bit bank and a 16-bit offset), a 16-bit I/O pointer and a 16-bit transfer count. Each accepted request then runs one memory read followed by one memory write. After that, the engine steps the pointers that are set to advance and decrements the count.

The service ends when the count reaches zero. It can also end early: if early termination is enabled and the peripheral raises its terminate line together with a request, the engine finishes the current transfer and then stops. Once the count is zero, the engine ignores further requests until software loads a new count.

The memory side is a valid/ready master. The engine raises `mem_valid` and keeps address, direction, size and write data unchanged until the cycle in which `mem_ready` is high. The transfer completes on that edge. The memory may stall for any number of cycles. The engine never drops or changes a request that is waiting. The control and status pins are plain levels or pulses.

Top module: `xfer_svc`

## Requirements
- R1: After reset, the control readback, both pointers and the count are zero. `mem_valid`, `svc_done`, `svc_end` and `svc_busy` are low.
- R2: Control register (select 0) fields:
  - bit 0: termination enable.
  - bit 1: direction.
  - bit 2: buffer pointer fixed.
  - bit 3: word size.
  - bit 4: I/O pointer fixed.

  Bits 7..5 always read back as 0, whatever value was written. The other selects are: 1 buffer pointer, 2 I/O pointer, 3 count.
- R3: With direction 0, the read goes to the I/O pointer (zero-extended to 24 bits) and the write goes to the buffer pointer. With direction 1, the read goes to the buffer pointer and the write goes to the I/O pointer.
- R4: In byte mode, `mem_size` is 0 and the write data is `{8'h00, read[7:0]}`. In word mode, `mem_size` is 1 and all 16 read bits are written.
- R5: After a transfer, every pointer whose fixed bit is 0 increments by 1 (byte) or 2 (word). A pointer whose fixed bit is 1 does not change. Pointers never decrement.
- R6: The buffer pointer advances only in its low 16 bits. A carry out of bit 15 is dropped and the bank byte is kept.
- R7: One request gives exactly one read handshake followed by one write handshake. While `mem_valid` is high and `mem_ready` is low, the address, `mem_we` and the write data stay unchanged.
- R8: `svc_done` is a one-cycle pulse. It rises one cycle after the write handshake, in the same cycle that the count shows its decremented value.
- R9: `svc_end` pulses together with `svc_done` when the transfer brings the count to zero.
- R10: If `svc_term` is high with an accepted request and termination is enabled, that transfer still runs, and afterwards `svc_end` pulses and the count becomes 0. If termination is disabled, `svc_term` has no effect.
- R11: A request is ignored while the count is zero or while a transfer is in progress.
- R12: Configuration writes that arrive while `svc_busy` is high are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 buffer pointer, 2 I/O pointer, 3 count |
| cfg_wdata | input | 24 | Configuration write data (low bits used for narrower registers) |
| svc_req | input | 1 | Peripheral service request |
| svc_term | input | 1 | Peripheral terminate request, sampled with `svc_req` |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts or completes the request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 1 | 1 = word, 0 = byte |
| mem_addr | output | 24 | Memory address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ready` on a read |
| svc_done | output | 1 | One-cycle pulse per completed transfer |
| svc_end | output | 1 | One-cycle pulse when the service finishes |
| svc_busy | output | 1 | A transfer is in progress |
| ctl_q | output | 8 | Control register readback |
| buf_ptr | output | 24 | Buffer pointer readback |
| io_ptr | output | 16 | I/O pointer readback |
| xfer_cnt | output | 16 | Remaining transfer count |

## Verification
The hardest case to reach from the ports combines three things in one transfer. The memory stalls for several cycles. During the stall, a second request and a configuration write arrive. Both must be lost, and the address on the bus must not move. The bench reaches this case by giving its memory model a programmable ready latency. It then pulses `svc_req` and writes the buffer pointer in the middle of the stall. After the transfer completes, it counts the handshakes and done pulses and reads back the pointer. The bank-preserving wrap is reached by loading an offset of `FFFF` in word mode.

// File: rtl/xfer_svc_pkg.sv
package xfer_svc_pkg;

  // Control register bit positions
  localparam int unsigned CTL_TERM  = 0;
  localparam int unsigned CTL_DIR   = 1;
  localparam int unsigned CTL_BFIX  = 2;
  localparam int unsigned CTL_WORD  = 3;
  localparam int unsigned CTL_IOFIX = 4;
  localparam int unsigned CTL_USED  = 5;

  // Configuration register selects
  localparam logic [1:0] SEL_CTL = 2'd0;
  localparam logic [1:0] SEL_BUF = 2'd1;
  localparam logic [1:0] SEL_IO  = 2'd2;
  localparam logic [1:0] SEL_CNT = 2'd3;

  typedef struct packed {
    logic term_en;
    logic dir_b2io;
    logic buf_fix;
    logic word;
    logic io_fix;
  } ctl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } seq_st_e;

endpackage

// File: rtl/xfer_svc_ctl.sv
module xfer_svc_ctl
  import xfer_svc_pkg::*;
#(
  parameter int CTL_W  = 8,
  parameter int USED_W = CTL_USED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [USED_W-1:0] wr_data,
  output logic [CTL_W-1:0]  ctl_q,
  output ctl_t              fields
);

  logic [USED_W-1:0] ctl_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_r <= '0;
    end else if (wr_en) begin
      ctl_r <= wr_data;
    end
  end

  // Unused upper bits read back as zero
  assign ctl_q = {{(CTL_W-USED_W){1'b0}}, ctl_r};

  always_comb begin
    fields.term_en  = ctl_r[CTL_TERM];
    fields.dir_b2io = ctl_r[CTL_DIR];
    fields.buf_fix  = ctl_r[CTL_BFIX];
    fields.word     = ctl_r[CTL_WORD];
    fields.io_fix   = ctl_r[CTL_IOFIX];
  end

endmodule

// File: rtl/xfer_svc_ptrs.sv
module xfer_svc_ptrs
  import xfer_svc_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int OFF_W  = 16,
  parameter int IO_W   = 16,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = BANK_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              adv,
  input  logic              word,
  input  logic              buf_fix,
  input  logic              io_fix,
  input  logic              term_hit,
  output logic [ADDR_W-1:0] buf_ptr,
  output logic [IO_W-1:0]   io_ptr,
  output logic [CNT_W-1:0]  cnt,
  output logic              cnt_nz,
  output logic              cnt_last
);

  logic [BANK_W-1:0] bank_r;
  logic [OFF_W-1:0]  off_r;
  logic [IO_W-1:0]   io_r;
  logic [CNT_W-1:0]  cnt_r;
  logic [OFF_W-1:0]  off_step;
  logic [IO_W-1:0]   io_step;

  assign off_step = word ? OFF_W'(2) : OFF_W'(1);
  assign io_step  = word ? IO_W'(2)  : IO_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_r <= '0;
      off_r  <= '0;
      io_r   <= '0;
      cnt_r  <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_BUF: {bank_r, off_r} <= wr_data;
        SEL_IO:  io_r  <= wr_data[IO_W-1:0];
        SEL_CNT: cnt_r <= wr_data[CNT_W-1:0];
        default: ;
      endcase
    end else if (adv) begin
      // Offset wraps inside its own width; the bank is never touched here
      if (!buf_fix) off_r <= off_r + off_step;
      if (!io_fix)  io_r  <= io_r + io_step;
      cnt_r <= term_hit ? '0 : cnt_r - CNT_W'(1);
    end
  end

  assign buf_ptr  = {bank_r, off_r};
  assign io_ptr   = io_r;
  assign cnt      = cnt_r;
  assign cnt_nz   = (cnt_r != '0);
  assign cnt_last = (cnt_r == CNT_W'(1));

  // R6
  bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_BUF) |=> buf_ptr[ADDR_W-1:OFF_W] == $past(buf_ptr[ADDR_W-1:OFF_W]));

  // R5
  io_no_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_en && io_fix) |=> io_ptr == $past(io_ptr));

endmodule

// File: rtl/xfer_svc_seq.sv
module xfer_svc_seq
  import xfer_svc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IO_W   = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              term,
  input  logic              cnt_nz,
  input  logic              cnt_last,
  input  ctl_t              ctl,
  input  logic [ADDR_W-1:0] buf_ptr,
  input  logic [IO_W-1:0]   io_ptr,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic              mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              fin,
  output logic              term_hit,
  output logic              busy,
  output logic              done_q,
  output logic              end_q
);

  localparam logic [DATA_W-1:0] LO_MASK = {{(DATA_W/2){1'b0}}, {(DATA_W-DATA_W/2){1'b1}}};

  seq_st_e           st;
  logic [DATA_W-1:0] data_r;
  logic              term_lat;
  logic              use_buf;
  logic [ADDR_W-1:0] io_ext;

  assign io_ext = {{(ADDR_W-IO_W){1'b0}}, io_ptr};

  always_comb begin
    mem_valid = (st != ST_IDLE);
    mem_we    = (st == ST_WR);
    use_buf   = (st == ST_WR) ? !ctl.dir_b2io : ctl.dir_b2io;
    mem_addr  = use_buf ? buf_ptr : io_ext;
    mem_size  = ctl.word;
    mem_wdata = data_r;
    fin       = (st == ST_WR) && mem_ready;
    busy      = (st != ST_IDLE);
    term_hit  = term_lat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      data_r   <= '0;
      term_lat <= 1'b0;
      done_q   <= 1'b0;
      end_q    <= 1'b0;
    end else begin
      done_q <= fin;
      end_q  <= fin && (cnt_last || term_lat);
      case (st)
        ST_IDLE: begin
          if (req && cnt_nz) begin
            st       <= ST_RD;
            term_lat <= term && ctl.term_en;
          end
        end
        ST_RD: begin
          if (mem_ready) begin
            st     <= ST_WR;
            data_r <= ctl.word ? mem_rdata : (mem_rdata & LO_MASK);
          end
        end
        ST_WR: begin
          if (mem_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R7
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we && mem_ready) |=> (mem_valid && mem_we));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/xfer_svc.sv
module xfer_svc
  import xfer_svc_pkg::*;
#(
  parameter int CTL_W  = 8,
  parameter int BANK_W = 8,
  parameter int OFF_W  = 16,
  parameter int IO_W   = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = BANK_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              svc_req,
  input  logic              svc_term,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic              mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              svc_done,
  output logic              svc_end,
  output logic              svc_busy,
  output logic [CTL_W-1:0]  ctl_q,
  output logic [ADDR_W-1:0] buf_ptr,
  output logic [IO_W-1:0]   io_ptr,
  output logic [CNT_W-1:0]  xfer_cnt
);

  ctl_t ctl;
  logic cfg_ok;
  logic fin;
  logic term_hit;
  logic cnt_nz;
  logic cnt_last;

  // Configuration is frozen while a transfer is in flight
  assign cfg_ok = cfg_we && !svc_busy;

  xfer_svc_ctl #(.CTL_W(CTL_W), .USED_W(CTL_USED)) ctl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_ok && cfg_sel == SEL_CTL),
    .wr_data (cfg_wdata[CTL_USED-1:0]),
    .ctl_q   (ctl_q),
    .fields  (ctl)
  );

  xfer_svc_ptrs #(
    .BANK_W(BANK_W), .OFF_W(OFF_W), .IO_W(IO_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) ptrs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_ok),
    .wr_sel   (cfg_sel),
    .wr_data  (cfg_wdata),
    .adv      (fin),
    .word     (ctl.word),
    .buf_fix  (ctl.buf_fix),
    .io_fix   (ctl.io_fix),
    .term_hit (term_hit),
    .buf_ptr  (buf_ptr),
    .io_ptr   (io_ptr),
    .cnt      (xfer_cnt),
    .cnt_nz   (cnt_nz),
    .cnt_last (cnt_last)
  );

  xfer_svc_seq #(.ADDR_W(ADDR_W), .IO_W(IO_W), .DATA_W(DATA_W)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (svc_req),
    .term      (svc_term),
    .cnt_nz    (cnt_nz),
    .cnt_last  (cnt_last),
    .ctl       (ctl),
    .buf_ptr   (buf_ptr),
    .io_ptr    (io_ptr),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_size  (mem_size),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .fin       (fin),
    .term_hit  (term_hit),
    .busy      (svc_busy),
    .done_q    (svc_done),
    .end_q     (svc_end)
  );

  // R9
  end_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_end |-> (xfer_cnt == '0 && svc_done));

  // R12
  busy_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_busy && cfg_we) |=> ($stable(ctl_q) && $stable(buf_ptr)));

endmodule

// File: tb/xfer_svc_tb_top.sv
`timescale 1ns/1ps
module xfer_svc_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [23:0] cfg_wdata = '0;
  logic        svc_req = 1'b0;
  logic        svc_term = 1'b0;
  logic        mem_valid, mem_we, mem_size;
  logic        mem_ready = 1'b0;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        svc_done, svc_end, svc_busy;
  logic [7:0]  ctl_q;
  logic [23:0] buf_ptr;
  logic [15:0] io_ptr, xfer_cnt;

  int n_run = 0;
  int n_fail = 0;
  int lat = 0;
  int wcnt = 0;
  int nhs = 0;
  int ndone = 0;
  logic [23:0] rd_a, wr_a;
  logic [15:0] wr_d;
  logic        wr_sz;
  logic        end_seen;

  always #10 clk = ~clk;

  xfer_svc dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .svc_req(svc_req), .svc_term(svc_term), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .svc_done(svc_done), .svc_end(svc_end), .svc_busy(svc_busy),
    .ctl_q(ctl_q), .buf_ptr(buf_ptr), .io_ptr(io_ptr), .xfer_cnt(xfer_cnt)
  );

  function automatic logic [15:0] pat(input logic [23:0] a);
    return a[15:0] ^ 16'h5A3C ^ {a[23:16], 8'h00};
  endfunction

  assign mem_rdata = pat(mem_addr);

  // Memory model with programmable ready latency; logs each accepted beat
  always @(negedge clk) begin
    if (svc_done) ndone <= ndone + 1;
    if (mem_ready) begin
      mem_ready <= 1'b0;
      wcnt <= 0;
    end else if (mem_valid) begin
      if (wcnt >= lat) begin
        mem_ready <= 1'b1;
        nhs <= nhs + 1;
        if (mem_we) begin
          wr_a <= mem_addr; wr_d <= mem_wdata; wr_sz <= mem_size;
        end else begin
          rd_a <= mem_addr;
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wcfg(input logic [1:0] sel, input logic [23:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [7:0] c, input logic [23:0] b, input logic [15:0] io, input logic [15:0] n);
    wcfg(2'd0, {16'h0, c});
    wcfg(2'd1, b);
    wcfg(2'd2, {8'h0, io});
    wcfg(2'd3, {8'h0, n});
  endtask

  // Issue one request and wait for the done pulse (sampled at negedge)
  task automatic run_req(input logic t);
    int n = 0;
    @(negedge clk);
    svc_req = 1'b1; svc_term = t;
    @(negedge clk);
    svc_req = 1'b0; svc_term = 1'b0;
    while (!svc_done && n < 100) begin
      @(negedge clk);
      n++;
    end
    end_seen = svc_end;
  endtask

  task automatic t_reset();
    chk(ctl_q == 8'h00, "R1 ctl", ctl_q, 0);
    chk(xfer_cnt == 16'h0 && buf_ptr == 24'h0 && io_ptr == 16'h0, "R1 regs", xfer_cnt, 0);
    chk(!mem_valid && !svc_done && !svc_end && !svc_busy, "R1 outputs", {mem_valid, svc_done, svc_end, svc_busy}, 0);
  endtask

  task automatic t_byte_io2buf();
    int h0;
    setup(8'h00, 24'h340100, 16'h0040, 16'd3);
    h0 = nhs;
    run_req(1'b0);
    chk(nhs == h0 + 2, "R7 two beats", nhs - h0, 2);
    chk(rd_a == 24'h000040, "R3 read io", rd_a, 24'h40);
    chk(wr_a == 24'h340100, "R3 write buf", wr_a, 24'h340100);
    chk(wr_d == {8'h00, pat(24'h40) & 16'h00FF} && wr_sz == 1'b0, "R4 byte data", wr_d, pat(24'h40) & 16'hFF);
    chk(buf_ptr == 24'h340101 && io_ptr == 16'h0041, "R5 byte step", buf_ptr, 24'h340101);
    chk(xfer_cnt == 16'd2 && !end_seen, "R8 count dec", xfer_cnt, 2);
  endtask

  task automatic t_word_buf2io();
    setup(8'h0E, 24'h560200, 16'h0080, 16'd4);
    run_req(1'b0);
    chk(rd_a == 24'h560200 && wr_a == 24'h000080, "R3 dir1", rd_a, 24'h560200);
    chk(wr_d == pat(24'h560200) && wr_sz == 1'b1, "R4 word data", wr_d, pat(24'h560200));
    chk(buf_ptr == 24'h560200 && io_ptr == 16'h0082, "R5 fixed buf word step io", buf_ptr, 24'h560200);
  endtask

  task automatic t_wrap_and_end();
    setup(8'h18, 24'h12FFFF, 16'h0010, 16'd2);
    run_req(1'b0);
    chk(buf_ptr == 24'h120001, "R6 wrap keeps bank", buf_ptr, 24'h120001);
    chk(io_ptr == 16'h0010, "R5 fixed io", io_ptr, 16'h10);
    chk(!end_seen, "R9 no end yet", end_seen, 0);
    run_req(1'b0);
    chk(end_seen && xfer_cnt == 16'd0, "R9 end at zero", {end_seen, xfer_cnt}, 32'h10000);
  endtask

  task automatic t_term();
    int h0;
    setup(8'h01, 24'h000100, 16'h0020, 16'd5);
    h0 = nhs;
    run_req(1'b1);
    chk(nhs == h0 + 2, "R10 transfer still done", nhs - h0, 2);
    chk(end_seen && xfer_cnt == 16'd0, "R10 term enabled ends", {end_seen, xfer_cnt}, 32'h10000);
    setup(8'h00, 24'h000100, 16'h0020, 16'd5);
    run_req(1'b1);
    chk(!end_seen && xfer_cnt == 16'd4, "R10 term disabled ignored", {end_seen, xfer_cnt}, 4);
  endtask

  task automatic t_zero_cnt();
    int h0, d0;
    wcfg(2'd3, 24'd0);
    h0 = nhs; d0 = ndone;
    @(negedge clk); svc_req = 1'b1;
    @(negedge clk); svc_req = 1'b0;
    repeat (10) @(negedge clk);
    chk(nhs == h0 && ndone == d0 && !svc_busy, "R11 zero count ignored", nhs - h0, 0);
  endtask

  task automatic t_reserved();
    wcfg(2'd0, 24'h0000FF);
    chk(ctl_q == 8'h1F, "R2 reserved read zero", ctl_q, 8'h1F);
    wcfg(2'd0, 24'h000000);
    chk(ctl_q == 8'h00, "R2 clear", ctl_q, 0);
  endtask

  task automatic t_stall_busy();
    int h0, d0, n;
    setup(8'h00, 24'h000010, 16'h0020, 16'd2);
    lat = 3;
    h0 = nhs; d0 = ndone;
    @(negedge clk); svc_req = 1'b1;
    @(negedge clk); svc_req = 1'b0;
    @(negedge clk);
    // Second request and a pointer write in the middle of the stall
    svc_req = 1'b1; cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 24'hABCDEF;
    @(negedge clk);
    svc_req = 1'b0; cfg_we = 1'b0;
    n = 0;
    while (!svc_done && n < 100) begin @(negedge clk); n++; end
    chk(wr_d == (pat(24'h20) & 16'h00FF) && rd_a == 24'h20, "R7 stalled data", wr_d, pat(24'h20) & 16'hFF);
    chk(buf_ptr == 24'h000011, "R12 write dropped while busy", buf_ptr, 24'h11);
    repeat (12) @(negedge clk);
    chk(nhs == h0 + 2 && ndone == d0 + 1, "R11 busy request ignored", nhs - h0, 2);
    lat = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_io2buf();
    t_word_buf2io();
    t_wrap_and_end();
    t_term();
    t_zero_cnt();
    t_reserved();
    t_stall_busy();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule